// File: doc/BRIEF.md
# Halt-Aware Two-Step Status Flag Bank

This block holds a bank of peripheral status flags. Hardware raises a flag with a one-cycle set pulse, and software clears it in two steps. Software first reads the status register while the flag is 1, which arms that flag. Software then reads or writes the data register, which clears every armed flag. The bank also tracks a debug-halt input. While the processor is halted, a software-owned clear-enable bit decides whether bus traffic may arm or clear flags. This lets a debugger inspect the registers without disturbing the peripheral's state.

The bank sits between the register bus and the flag consumers. It drives the flag vector straight to its outputs. It returns the status and control registers on a combinational read data port.

Top module: `sfc_flag_bank`

## Requirements
- R1: After a synchronous active-low reset, every flag and every arm bit is 0 and the clear-enable bit is 0. A read of the control register (address 2) returns 0.
- R2: A 1 on bit i of the hardware set input makes flag i read 1 from the next clock edge onward. A read of the status register (address 0) returns the flags in bits [NUM_FLAGS-1:0] and 0 above them.
- R3: A status read that happens while a flag is 1 arms that flag. A later read or write of the data register (address 1) clears every armed flag at the next edge and disarms it.
- R4: A status read arms only the flags that are 1 during that read. A flag that is set after the read is not cleared by the following data register access.
- R5: A data register access clears no flag that is unarmed.
- R6: When a set pulse and a clearing data access arrive in the same cycle, the flag stays 1 and its arm is dropped. A second data access therefore does not clear it.
- R7: While the halt input is 1 and clear-enable is 0, status reads and data accesses change no flag and no arm. A flag armed before the halt is still armed afterwards, and a data access after the halt ends clears it.
- R8: While the halt input is 1 and clear-enable is 0, a status read arms nothing. A data access after the halt ends leaves the flag set.
- R9: While the halt input is 1 and clear-enable is 1, the two-step clear works as normal. A flag cleared this way stays 0 after the halt ends.
- R10: A write to the control register (address 2) loads write data bit 0 into clear-enable, and a read of that address returns it in bit 0. Writes to it are accepted during a halt.
- R11: Hardware set pulses set flags during a halt regardless of clear-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 data, 2 control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data; bit 0 is used for the control register |
| bus_rdata | output | DATA_W | Combinational read data, 0 when bus_rd is low |
| hw_set | input | NUM_FLAGS | Per-flag set pulses from the peripheral |
| dbg_halt | input | 1 | 1 while the processor is halted for debug |
| flags_o | output | NUM_FLAGS | Current flag values |

## Verification
The two-step clear is tried four ways. A full clear separates arming from clearing. A flag set between the two steps separates "armed at read time" from "set now". A data access with no preceding read shows that step two alone does nothing. A set pulse that coincides with a clear shows the set has priority and that the arm is dropped. The same sequence is then split around a halt under each clear-enable value. This tells apart three cases: an arm kept through the halt, an arm that is never made during it, and a clear that is allowed during it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   localparam int ADDR_STAT = 0;
   localparam int ADDR_DATA = 1;
   localparam int ADDR_CTRL = 2;

   typedef struct packed {
      logic stat_rd;
      logic data_acc;
      logic ctrl_wr;
      logic ctrl_rd;
   } sfc_bus_ev_t;

endpackage

// File: rtl/sfc_bus_decode.sv
module sfc_bus_decode #(
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   output sfc_pkg::sfc_bus_ev_t ev
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(sfc_pkg::ADDR_STAT);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(sfc_pkg::ADDR_DATA);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(sfc_pkg::ADDR_CTRL);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sfc_bus_decode: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      ev.stat_rd  = bus_rd && (bus_addr == A_STAT);
      ev.data_acc = (bus_rd || bus_wr) && (bus_addr == A_DATA);
      ev.ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
      ev.ctrl_rd  = bus_rd && (bus_addr == A_CTRL);
   end
endmodule

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic clr_en
);
   always_ff @(posedge clk) begin
      if (!rst_n)     clr_en <= 1'b0;
      else if (wr_en) clr_en <= wr_bit;
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(clr_en)) else $error("clear-enable moved without a write"); // R10
endmodule

// File: rtl/sfc_flag_cell.sv
module sfc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic arm_req,
   input  logic clr_req,
   output logic flag_q,
   output logic armed_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (set_i) begin
         flag_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (clr_req && armed_q) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (arm_req && flag_q) begin
         armed_q <= 1'b1;
      end
   end

   AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> flag_q) else $error("arm without flag"); // R4
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q && !armed_q) else $error("set lost"); // R6
   AST_ARMED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && armed_q && !set_i) |=> !flag_q) else $error("armed flag not cleared"); // R3
   AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q && !arm_req) |=> flag_q) else $error("unarmed flag dropped"); // R5
endmodule

// File: rtl/sfc_flag_bank.sv
module sfc_flag_bank #(
   parameter int NUM_FLAGS = 4,
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_FLAGS-1:0] hw_set,
   input  logic                 dbg_halt,
   output logic [NUM_FLAGS-1:0] flags_o
);
   localparam int PAD_W = DATA_W - NUM_FLAGS;

   generate
      if (NUM_FLAGS < 1 || NUM_FLAGS > DATA_W) begin : g_bad_flags
         $error("sfc_flag_bank: NUM_FLAGS must be in 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sfc_flag_bank: DATA_W must be at least 2");
      end
   endgenerate

   sfc_pkg::sfc_bus_ev_t ev;
   logic                 clr_en;
   logic                 access_ok;
   logic [NUM_FLAGS-1:0] armed;

   sfc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .ev       (ev)
   );

   sfc_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ev.ctrl_wr),
      .wr_bit (bus_wdata[0]),
      .clr_en (clr_en)
   );

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:1];

   // Bus traffic may touch flags outside a halt, or inside one when enabled.
   assign access_ok = !dbg_halt || clr_en;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
         sfc_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (hw_set[i]),
            .arm_req (ev.stat_rd && access_ok),
            .clr_req (ev.data_acc && access_ok),
            .flag_q  (flags_o[i]),
            .armed_q (armed[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (ev.stat_rd)      bus_rdata = {{PAD_W{1'b0}}, flags_o};
      else if (ev.ctrl_rd) bus_rdata = {{(DATA_W-1){1'b0}}, clr_en};
   end

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !clr_en && hw_set == '0) |=> (flags_o == $past(flags_o)) && (armed == $past(armed)))
      else $error("flag state moved during protected halt"); // R7
   AST_HALT_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !clr_en && armed == '0 && hw_set == '0) |=> armed == '0)
      else $error("arm made during protected halt"); // R8
   AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((flags_o & $past(hw_set)) == $past(hw_set)))
      else $error("set pulse not seen on flags"); // R11
   AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set == '0) |=> ((flags_o & ~$past(flags_o)) == '0))
      else $error("flag rose without set"); // R2
endmodule

// File: tb/sfc_flag_bank_tb.sv
`timescale 1ns/1ps
module sfc_flag_bank_tb;
   localparam int NF = 4;
   localparam int AW = 2;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NF-1:0] hw_set = '0;
   logic          dbg_halt = 1'b0;
   logic [NF-1:0] flags_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sfc_flag_bank #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_set(hw_set), .dbg_halt(dbg_halt), .flags_o(flags_o)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bus cycle; rdata sampled 1 ns after inputs settle, before the edge.
   task automatic cyc(input logic rd, input logic wr, input int addr,
                      input logic [DW-1:0] wd, input logic [NF-1:0] hs,
                      output logic [DW-1:0] rdat);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd; hw_set = hs;
      #1 rdat = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; hw_set = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; dbg_halt = 1'b0;
      bus_rd = 1'b0; bus_wr = 1'b0; hw_set = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [DW-1:0] r;
      do_reset();
      check("R1 flags", DW'(flags_o), 8'h00);
      cyc(1, 0, 2, 0, 0, r);
      check("R1 ctrl", r, 8'h00);
      cyc(1, 0, 0, 0, 0, r);
      check("R1 status", r, 8'h00);
   endtask

   task automatic t_two_step();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0101, r);
      check("R2 set", DW'(flags_o), 8'h05);
      cyc(1, 0, 0, 0, 0, r);
      check("R2 status read", r, 8'h05);
      cyc(1, 0, 1, 0, 0, r);
      check("R3 clear by data read", DW'(flags_o), 8'h00);
      cyc(0, 0, 3, 0, 4'b0010, r);
      cyc(1, 0, 0, 0, 0, r);
      cyc(0, 1, 1, 8'h5a, 0, r);
      check("R3 clear by data write", DW'(flags_o), 8'h00);
   endtask

   task automatic t_partial_arm();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0001, r);
      cyc(1, 0, 0, 0, 0, r);
      cyc(0, 0, 3, 0, 4'b0010, r);
      cyc(0, 1, 1, 0, 0, r);
      check("R4 late flag kept", DW'(flags_o), 8'h02);
   endtask

   task automatic t_no_arm();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0011, r);
      cyc(0, 1, 1, 0, 0, r);
      cyc(1, 0, 1, 0, 0, r);
      check("R5 unarmed kept", DW'(flags_o), 8'h03);
   endtask

   task automatic t_set_wins();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0001, r);
      cyc(1, 0, 0, 0, 0, r);
      cyc(1, 0, 1, 0, 4'b0001, r);
      check("R6 set beats clear", DW'(flags_o), 8'h01);
      cyc(1, 0, 1, 0, 0, r);
      check("R6 arm dropped", DW'(flags_o), 8'h01);
   endtask

   task automatic t_halt_protect();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0011, r);
      cyc(1, 0, 0, 0, 0, r);
      dbg_halt = 1'b1;
      cyc(1, 0, 0, 0, 0, r);
      check("R7 status readable in halt", r, 8'h03);
      cyc(1, 0, 1, 0, 0, r);
      cyc(0, 1, 1, 0, 0, r);
      check("R7 frozen in halt", DW'(flags_o), 8'h03);
      dbg_halt = 1'b0;
      cyc(1, 0, 1, 0, 0, r);
      check("R7 arm survives halt", DW'(flags_o), 8'h00);
   endtask

   task automatic t_halt_no_arm();
      logic [DW-1:0] r;
      do_reset();
      cyc(0, 0, 3, 0, 4'b0100, r);
      dbg_halt = 1'b1;
      cyc(1, 0, 0, 0, 0, r);
      dbg_halt = 1'b0;
      cyc(1, 0, 1, 0, 0, r);
      check("R8 no arm in halt", DW'(flags_o), 8'h04);
      cyc(1, 0, 0, 0, 0, r);
      cyc(1, 0, 1, 0, 0, r);
      check("R8 normal after halt", DW'(flags_o), 8'h00);
   endtask

   task automatic t_halt_enabled();
      logic [DW-1:0] r;
      do_reset();
      dbg_halt = 1'b1;
      cyc(0, 1, 2, 8'h01, 0, r);
      cyc(1, 0, 2, 0, 0, r);
      check("R10 ctrl write in halt", r, 8'h01);
      cyc(0, 0, 3, 0, 4'b1000, r);
      check("R11 set in halt", DW'(flags_o), 8'h08);
      cyc(1, 0, 0, 0, 0, r);
      cyc(1, 0, 1, 0, 0, r);
      check("R9 clear in enabled halt", DW'(flags_o), 8'h00);
      dbg_halt = 1'b0;
      cyc(0, 0, 3, 0, 0, r);
      check("R9 stays cleared", DW'(flags_o), 8'h00);
      cyc(0, 1, 2, 8'hfe, 0, r);
      cyc(1, 0, 2, 0, 0, r);
      check("R10 ctrl bit0 only", r, 8'h00);
   endtask

   initial begin
      t_reset();
      t_two_step();
      t_partial_arm();
      t_no_arm();
      t_set_wins();
      t_halt_protect();
      t_halt_no_arm();
      t_halt_enabled();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule